// File: doc/BRIEF.md
# Bank Activation Timing Tracker

This block sits beside a DRAM command scheduler and follows every command that the scheduler puts on the bus. It keeps track of four banks. For each bank it records whether a row is open and which row that is. From the age of each open row and the spacing between recent activates, it produces three permission vectors: one for column access, one for closing a row and one for opening a row. The scheduler combines these vectors with its own queue to decide what to issue next.

Each timing limit is given in picoseconds along with the clock period. The block turns each limit into a whole number of cycles by rounding up. A row that has been open for a long time raises a forced-close request a set number of cycles before its longest legal open time runs out. A row that is held open beyond that time raises an overdue flag.

Commands that cannot apply to the bank's current state are dropped and reported. These are an activate to an open bank and a read or write to a closed bank. Commands that are legal but issued too early still take effect, and they raise a timing-error pulse.

Each bank runs a small state machine with these states:
- `BK_CLOSED`: no row is open.
- `BK_OPENING`: a row is open, but the activate-to-column delay has not yet passed.
- `BK_READY`: column access is allowed.
- `BK_AGING`: the row is close to its maximum open time.

The transitions are:
- activate: `BK_CLOSED` → `BK_OPENING`.
- delay met: `BK_OPENING` → `BK_READY`.
- warning reached: `BK_READY` or `BK_OPENING` → `BK_AGING`.
- precharge: any open state → `BK_CLOSED`.

Top module: `bank_timing_tracker`

## Requirements
- R1: After reset, all banks are closed. `act_ok` is all ones. `rdwr_ok`, `pre_ok`, `force_pre_req`, `ras_overdue` and all three error outputs are zero.
- R2: `cmd_op` encodes commands as follows: 2'b00 is activate, 2'b01 is read, 2'b10 is write and 2'b11 is precharge. `cmd_bank` selects bank 0 to 3. An activate to a closed bank sets that bank's bit in `bank_open` from the next cycle. It also stores `cmd_row` in that bank's `ROW_W` slice of `open_row`, where bank b occupies bits [b*ROW_W +: ROW_W].
- R3: `rdwr_ok[b]` is low for the first RCD-1 cycles after an activate to bank b. It goes high RCD cycles after the activate, where RCD = ceil(T_RCD_PS/CLK_PS).
- R4: After any activate, `act_ok` is low for every bank until RRD = ceil(T_RRD_PS/CLK_PS) cycles have passed. After that, it is high for each closed bank.
- R5: `pre_ok[b]` goes high RASMIN = ceil(T_RAS_MIN_PS/CLK_PS) cycles after the activate to bank b, and not earlier.
- R6: `force_pre_req[b]` goes high RASMAX − WARN_CYC cycles after the activate, where RASMAX = ceil(T_RAS_MAX_PS/CLK_PS). It stays high until the bank is precharged.
- R7: `ras_overdue[b]` goes high once bank b has been open for more than RASMAX cycles. It stays high, without wrapping, until the bank is precharged.
- R8: A precharge to an open bank closes it from the next cycle. At that point its `bank_open`, `rdwr_ok`, `pre_ok`, `force_pre_req` and `ras_overdue` bits are all zero. A precharge to a closed bank changes nothing and reports no error.
- R9: An activate to an open bank is dropped. `err_act_open` pulses for one cycle, and the stored row is unchanged.
- R10: A read or write to a closed bank is dropped. `err_col_closed` pulses for one cycle, and `col_addr` and `col_bank` are unchanged.
- R11: A read or write to an open bank stores `cmd_col` in `col_addr` and `cmd_bank` in `col_bank` from the next cycle.
- R12: A command that is applied while its permission bit is low pulses `err_timing` for one cycle. The command still takes effect. This covers an activate with `act_ok` low on a closed bank, a column command with `rdwr_ok` low on an open bank, and a precharge with `pre_ok` low on an open bank.
- R13: Each limit in cycles is the picosecond value divided by `CLK_PS` and rounded up. With the default values this gives RCD=3, RRD=2, RASMIN=6 and RASMAX=50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_op | input | 2 | Command code |
| cmd_bank | input | BA_W | Target bank |
| cmd_row | input | ROW_W | Row address, used with activate |
| cmd_col | input | COL_W | Column address, used with read or write |
| bank_open | output | 4 | A row is open in each bank |
| open_row | output | 4*ROW_W | Stored row for each bank |
| col_addr | output | COL_W | Last accepted column address |
| col_bank | output | BA_W | Bank of the last accepted column command |
| rdwr_ok | output | 4 | Read or write permitted per bank |
| pre_ok | output | 4 | Precharge permitted per bank |
| act_ok | output | 4 | Activate permitted per bank |
| force_pre_req | output | 4 | Row nearing its maximum open time |
| ras_overdue | output | 4 | Row open longer than the maximum |
| err_act_open | output | 1 | Activate to an open bank was dropped |
| err_col_closed | output | 1 | Column command to a closed bank was dropped |
| err_timing | output | 1 | Command issued against a low permission |

## Verification
The checker assumes that at most one command arrives per cycle. It also assumes that `cmd_op` and `cmd_bank` are valid binary values whenever `cmd_valid` is high. Its own age counters measure time from the cycle in which an activate reaches a closed bank. The bench drives each command for exactly one cycle on the falling edge and releases `cmd_valid` afterwards, so every command is seen once. The deliberate violations in the bench are there to exercise the error outputs. They are ordered so that the permission-versus-age properties are still met.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

    typedef enum logic [1:0] {
        OP_ACT = 2'b00,
        OP_RD  = 2'b01,
        OP_WR  = 2'b10,
        OP_PRE = 2'b11
    } cmd_op_e;

    typedef enum logic [1:0] {
        BK_CLOSED,
        BK_OPENING,
        BK_READY,
        BK_AGING
    } bank_st_e;

    // Rounds a duration up to whole clock periods.
    function automatic int unsigned cyc_ceil(input int unsigned dur_ps,
                                             input int unsigned per_ps);
        return (dur_ps + per_ps - 1) / per_ps;
    endfunction

endpackage

// File: rtl/act_spacing_ctr.sv
module act_spacing_ctr #(
    parameter int unsigned RRD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_act,
    output logic spacing_met
);
    localparam int unsigned SP_W = (RRD_CYC < 2) ? 1 : $clog2(RRD_CYC + 1);
    localparam logic [SP_W-1:0] SP_LIM = SP_W'(RRD_CYC);

    logic [SP_W-1:0] sp_q;

    // Saturating count of cycles since the most recent activate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= SP_LIM;
        end else if (any_act) begin
            sp_q <= SP_W'(1);
        end else if (sp_q < SP_LIM) begin
            sp_q <= sp_q + SP_W'(1);
        end
    end

    assign spacing_met = (sp_q >= SP_LIM);

endmodule

// File: rtl/bank_state_fsm.sv
module bank_state_fsm
    import bank_trk_pkg::*;
#(
    parameter int unsigned ROW_W       = 13,
    parameter int unsigned CNT_W       = 6,
    parameter int unsigned RCD_CYC     = 3,
    parameter int unsigned RAS_MIN_CYC = 6,
    parameter int unsigned RAS_MAX_CYC = 50,
    parameter int unsigned WARN_AT     = 42
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_act,
    input  logic             do_pre,
    input  logic [ROW_W-1:0] act_row,
    output logic             is_open,
    output logic [ROW_W-1:0] row_q,
    output logic             rdwr_ok,
    output logic             pre_ok,
    output logic             force_req,
    output logic             overdue
);
    localparam logic [CNT_W-1:0] L_RCD  = CNT_W'(RCD_CYC);
    localparam logic [CNT_W-1:0] L_RMIN = CNT_W'(RAS_MIN_CYC);
    localparam logic [CNT_W-1:0] L_RMAX = CNT_W'(RAS_MAX_CYC);
    localparam logic [CNT_W-1:0] L_WARN = CNT_W'(WARN_AT);
    localparam logic [CNT_W-1:0] L_SAT  = CNT_W'(RAS_MAX_CYC + 1);

    bank_st_e        state_q, state_d;
    logic [CNT_W-1:0] age_q, age_d;

    // Next age and next state.
    always_comb begin
        age_d = age_q;
        if (do_act && state_q == BK_CLOSED) begin
            age_d = CNT_W'(1);
        end else if (do_pre) begin
            age_d = '0;
        end else if (state_q != BK_CLOSED && age_q != L_SAT) begin
            age_d = age_q + CNT_W'(1);
        end

        if (age_d == '0) begin
            state_d = BK_CLOSED;
        end else if (age_d >= L_WARN) begin
            state_d = BK_AGING;
        end else if (age_d >= L_RCD) begin
            state_d = BK_READY;
        end else begin
            state_d = BK_OPENING;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_CLOSED;
            age_q   <= '0;
        end else begin
            state_q <= state_d;
            age_q   <= age_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (do_act && state_q == BK_CLOSED) begin
            row_q <= act_row;
        end
    end

    // Outputs.
    always_comb begin
        is_open   = 1'b0;
        rdwr_ok   = 1'b0;
        pre_ok    = 1'b0;
        force_req = 1'b0;
        overdue   = 1'b0;
        unique case (state_q)
            BK_CLOSED: begin
            end
            BK_OPENING: begin
                is_open = 1'b1;
                pre_ok  = (age_q >= L_RMIN);
            end
            BK_READY: begin
                is_open = 1'b1;
                rdwr_ok = 1'b1;
                pre_ok  = (age_q >= L_RMIN);
            end
            BK_AGING: begin
                is_open   = 1'b1;
                rdwr_ok   = (age_q >= L_RCD);
                pre_ok    = (age_q >= L_RMIN);
                force_req = 1'b1;
                overdue   = (age_q > L_RMAX);
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
    import bank_trk_pkg::*;
#(
    parameter int unsigned BA_W  = 2,
    parameter int unsigned COL_W = 10,
    localparam int unsigned NB   = 1 << BA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [BA_W-1:0]  cmd_bank,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [NB-1:0]    bank_open,
    input  logic [NB-1:0]    rdwr_ok,
    input  logic [NB-1:0]    pre_ok,
    input  logic             spacing_met,
    output logic [NB-1:0]    act_go,
    output logic [NB-1:0]    pre_go,
    output logic             any_act_go,
    output logic             err_act_open,
    output logic             err_col_closed,
    output logic             err_timing,
    output logic [COL_W-1:0] col_addr,
    output logic [BA_W-1:0]  col_bank
);
    cmd_op_e op;
    logic    is_act, is_pre, is_col, tgt_open, col_go;
    logic    e_dup_d, e_closed_d, e_time_d;

    assign op       = cmd_op_e'(cmd_op);
    assign is_act   = cmd_valid && (op == OP_ACT);
    assign is_pre   = cmd_valid && (op == OP_PRE);
    assign is_col   = cmd_valid && (op == OP_RD || op == OP_WR);
    assign tgt_open = bank_open[cmd_bank];
    assign col_go   = is_col && tgt_open;

    for (genvar b = 0; b < NB; b++) begin : g_go
        assign act_go[b] = is_act && (cmd_bank == BA_W'(b)) && !bank_open[b];
        assign pre_go[b] = is_pre && (cmd_bank == BA_W'(b)) && bank_open[b];
    end

    assign any_act_go = |act_go;

    assign e_dup_d    = is_act && tgt_open;
    assign e_closed_d = is_col && !tgt_open;
    assign e_time_d   = (any_act_go && !spacing_met)
                      | (col_go && !rdwr_ok[cmd_bank])
                      | ((|pre_go) && !pre_ok[cmd_bank]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_act_open   <= 1'b0;
            err_col_closed <= 1'b0;
            err_timing     <= 1'b0;
        end else begin
            err_act_open   <= e_dup_d;
            err_col_closed <= e_closed_d;
            err_timing     <= e_time_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_addr <= '0;
            col_bank <= '0;
        end else if (col_go) begin
            col_addr <= cmd_col;
            col_bank <= cmd_bank;
        end
    end

endmodule

// File: rtl/bank_timing_tracker.sv
module bank_timing_tracker
    import bank_trk_pkg::*;
#(
    parameter int unsigned BA_W         = 2,
    parameter int unsigned ROW_W        = 13,
    parameter int unsigned COL_W        = 10,
    parameter int unsigned CLK_PS       = 8000,
    parameter int unsigned T_RCD_PS     = 19000,
    parameter int unsigned T_RRD_PS     = 15000,
    parameter int unsigned T_RAS_MIN_PS = 42000,
    parameter int unsigned T_RAS_MAX_PS = 400000,
    parameter int unsigned WARN_CYC     = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cmd_valid,
    input  logic [1:0]                     cmd_op,
    input  logic [BA_W-1:0]                cmd_bank,
    input  logic [ROW_W-1:0]               cmd_row,
    input  logic [COL_W-1:0]               cmd_col,
    output logic [(1<<BA_W)-1:0]           bank_open,
    output logic [(1<<BA_W)*ROW_W-1:0]     open_row,
    output logic [COL_W-1:0]               col_addr,
    output logic [BA_W-1:0]                col_bank,
    output logic [(1<<BA_W)-1:0]           rdwr_ok,
    output logic [(1<<BA_W)-1:0]           pre_ok,
    output logic [(1<<BA_W)-1:0]           act_ok,
    output logic [(1<<BA_W)-1:0]           force_pre_req,
    output logic [(1<<BA_W)-1:0]           ras_overdue,
    output logic                           err_act_open,
    output logic                           err_col_closed,
    output logic                           err_timing
);
    localparam int unsigned NB          = 1 << BA_W;
    localparam int unsigned RCD_CYC     = cyc_ceil(T_RCD_PS, CLK_PS);
    localparam int unsigned RRD_CYC     = cyc_ceil(T_RRD_PS, CLK_PS);
    localparam int unsigned RAS_MIN_CYC = cyc_ceil(T_RAS_MIN_PS, CLK_PS);
    localparam int unsigned RAS_MAX_CYC = cyc_ceil(T_RAS_MAX_PS, CLK_PS);
    localparam int unsigned WARN_AT     = (WARN_CYC < RAS_MAX_CYC) ? (RAS_MAX_CYC - WARN_CYC) : 1;
    localparam int unsigned CNT_W       = $clog2(RAS_MAX_CYC + 2);

    logic [NB-1:0] act_go, pre_go;
    logic          any_act_go, spacing_met;

    cmd_decode #(
        .BA_W (BA_W),
        .COL_W(COL_W)
    ) dec_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_op        (cmd_op),
        .cmd_bank      (cmd_bank),
        .cmd_col       (cmd_col),
        .bank_open     (bank_open),
        .rdwr_ok       (rdwr_ok),
        .pre_ok        (pre_ok),
        .spacing_met   (spacing_met),
        .act_go        (act_go),
        .pre_go        (pre_go),
        .any_act_go    (any_act_go),
        .err_act_open  (err_act_open),
        .err_col_closed(err_col_closed),
        .err_timing    (err_timing),
        .col_addr      (col_addr),
        .col_bank      (col_bank)
    );

    act_spacing_ctr #(
        .RRD_CYC(RRD_CYC)
    ) spc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_act    (any_act_go),
        .spacing_met(spacing_met)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        bank_state_fsm #(
            .ROW_W      (ROW_W),
            .CNT_W      (CNT_W),
            .RCD_CYC    (RCD_CYC),
            .RAS_MIN_CYC(RAS_MIN_CYC),
            .RAS_MAX_CYC(RAS_MAX_CYC),
            .WARN_AT    (WARN_AT)
        ) fsm_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .do_act   (act_go[b]),
            .do_pre   (pre_go[b]),
            .act_row  (cmd_row),
            .is_open  (bank_open[b]),
            .row_q    (open_row[b*ROW_W +: ROW_W]),
            .rdwr_ok  (rdwr_ok[b]),
            .pre_ok   (pre_ok[b]),
            .force_req(force_pre_req[b]),
            .overdue  (ras_overdue[b])
        );
        assign act_ok[b] = !bank_open[b] && spacing_met;
    end

endmodule

// File: rtl/bank_timing_tracker_chk.sv
module bank_timing_tracker_chk
    import bank_trk_pkg::*;
#(
    parameter int unsigned BA_W         = 2,
    parameter int unsigned ROW_W        = 13,
    parameter int unsigned COL_W        = 10,
    parameter int unsigned CLK_PS       = 8000,
    parameter int unsigned T_RCD_PS     = 19000,
    parameter int unsigned T_RRD_PS     = 15000,
    parameter int unsigned T_RAS_MIN_PS = 42000,
    parameter int unsigned T_RAS_MAX_PS = 400000,
    parameter int unsigned WARN_CYC     = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cmd_valid,
    input logic [1:0]                     cmd_op,
    input logic [BA_W-1:0]                cmd_bank,
    input logic [ROW_W-1:0]               cmd_row,
    input logic [COL_W-1:0]               cmd_col,
    input logic [(1<<BA_W)-1:0]           bank_open,
    input logic [(1<<BA_W)*ROW_W-1:0]     open_row,
    input logic [COL_W-1:0]               col_addr,
    input logic [BA_W-1:0]                col_bank,
    input logic [(1<<BA_W)-1:0]           rdwr_ok,
    input logic [(1<<BA_W)-1:0]           pre_ok,
    input logic [(1<<BA_W)-1:0]           act_ok,
    input logic [(1<<BA_W)-1:0]           force_pre_req,
    input logic [(1<<BA_W)-1:0]           ras_overdue,
    input logic                           err_act_open,
    input logic                           err_col_closed,
    input logic                           err_timing
);
    localparam int unsigned NB    = 1 << BA_W;
    localparam int unsigned RCD   = cyc_ceil(T_RCD_PS, CLK_PS);
    localparam int unsigned RRD   = cyc_ceil(T_RRD_PS, CLK_PS);
    localparam int unsigned RMIN  = cyc_ceil(T_RAS_MIN_PS, CLK_PS);
    localparam int unsigned RMAX  = cyc_ceil(T_RAS_MAX_PS, CLK_PS);
    localparam int unsigned WAT   = (WARN_CYC < RMAX) ? (RMAX - WARN_CYC) : 1;
    localparam int unsigned AW    = 32;

    logic          is_act, is_pre, is_col;
    logic [AW-1:0] rrd_age;

    assign is_act = cmd_valid && (cmd_op == 2'b00);
    assign is_pre = cmd_valid && (cmd_op == 2'b11);
    assign is_col = cmd_valid && (cmd_op == 2'b01 || cmd_op == 2'b10);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrd_age <= AW'(RRD);
        end else if (is_act && !bank_open[cmd_bank]) begin
            rrd_age <= AW'(1);
        end else if (rrd_age < AW'(RRD)) begin
            rrd_age <= rrd_age + AW'(1);
        end
    end

    // R4
    rrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_ok != '0) |-> (rrd_age >= AW'(RRD)));

    // R9
    act_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && bank_open[cmd_bank]) |=> err_act_open);

    // R10
    col_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_col && !bank_open[cmd_bank]) |=> (err_col_closed && $stable(col_addr)));

    for (genvar b = 0; b < NB; b++) begin : g_chk
        logic [AW-1:0] age;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                age <= '0;
            end else if (is_act && cmd_bank == BA_W'(b) && !bank_open[b]) begin
                age <= AW'(1);
            end else if (is_pre && cmd_bank == BA_W'(b)) begin
                age <= '0;
            end else if (age != '0 && age < AW'(RMAX + 2)) begin
                age <= age + AW'(1);
            end
        end

        // R2
        act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (is_act && cmd_bank == BA_W'(b)) |=> bank_open[b]);

        // R3
        rdwr_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rdwr_ok[b] |-> (age >= AW'(RCD)));

        // R5
        pre_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pre_ok[b] |-> (age >= AW'(RMIN)));

        // R6
        force_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
            force_pre_req[b] |-> (age >= AW'(WAT)));

        // R7
        overdue_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ras_overdue[b] |-> (bank_open[b] && age > AW'(RMAX)));

        // R8
        pre_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (is_pre && cmd_bank == BA_W'(b)) |=> !bank_open[b]);
    end

endmodule

bind bank_timing_tracker bank_timing_tracker_chk #(
    .BA_W        (BA_W),
    .ROW_W       (ROW_W),
    .COL_W       (COL_W),
    .CLK_PS      (CLK_PS),
    .T_RCD_PS    (T_RCD_PS),
    .T_RRD_PS    (T_RRD_PS),
    .T_RAS_MIN_PS(T_RAS_MIN_PS),
    .T_RAS_MAX_PS(T_RAS_MAX_PS),
    .WARN_CYC    (WARN_CYC)
) chk_i (.*);

// File: tb/bank_timing_tracker_tb_top.sv
`timescale 1ns/1ps
module bank_timing_tracker_tb_top;

    localparam int ROW_W = 13;
    localparam int COL_W = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'b00;
    logic [1:0]        cmd_bank = 2'b00;
    logic [ROW_W-1:0]  cmd_row = '0;
    logic [COL_W-1:0]  cmd_col = '0;
    logic [3:0]        bank_open, rdwr_ok, pre_ok, act_ok, force_pre_req, ras_overdue;
    logic [4*ROW_W-1:0] open_row;
    logic [COL_W-1:0]  col_addr;
    logic [1:0]        col_bank;
    logic              err_act_open, err_col_closed, err_timing;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bank_timing_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .bank_open(bank_open), .open_row(open_row), .col_addr(col_addr),
        .col_bank(col_bank), .rdwr_ok(rdwr_ok), .pre_ok(pre_ok), .act_ok(act_ok),
        .force_pre_req(force_pre_req), .ras_overdue(ras_overdue),
        .err_act_open(err_act_open), .err_col_closed(err_col_closed),
        .err_timing(err_timing)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [1:0] bk,
                         input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col);
        cmd_valid = 1'b1; cmd_op = op; cmd_bank = bk; cmd_row = row; cmd_col = col;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [ROW_W-1:0] row_of(input int b);
        return open_row[b*ROW_W +: ROW_W];
    endfunction

    task automatic t_reset;
        chk("R1 bank_open", bank_open, 0);
        chk("R1 act_ok", act_ok, 4'hF);
        chk("R1 rdwr/pre/force/overdue", {rdwr_ok, pre_ok, force_pre_req, ras_overdue}, 0);
        chk("R1 errors", {err_act_open, err_col_closed, err_timing}, 0);
    endtask

    task automatic t_open_and_column;
        issue(2'b00, 2'd1, 13'h123, 0);          // activate, age 1
        chk("R2 bank_open", bank_open, 4'b0010);
        chk("R2 row", row_of(1), 13'h123);
        chk("R3 rdwr at age 1", rdwr_ok[1], 0);
        chk("R4 act_ok at 1", act_ok, 4'b0000);
        idle(1);                                  // age 2
        chk("R3 rdwr at age 2", rdwr_ok[1], 0);
        chk("R4 act_ok at 2", act_ok, 4'b1101);
        idle(1);                                  // age 3, R13: 19000/8000 -> 3
        chk("R3 R13 rdwr at age 3", rdwr_ok[1], 1);
        issue(2'b01, 2'd1, 0, 10'h02A);          // read, age 4 after
        chk("R11 col_addr", col_addr, 10'h02A);
        chk("R11 col_bank", col_bank, 2'd1);
        chk("R12 no timing err", err_timing, 0);
        chk("R5 pre at age 4", pre_ok[1], 0);
        idle(1);
        chk("R5 pre at age 5", pre_ok[1], 0);
        idle(1);
        chk("R5 pre at age 6", pre_ok[1], 1);
        issue(2'b11, 2'd1, 0, 0);
        chk("R8 closed", bank_open, 0);
        chk("R8 perms cleared", {rdwr_ok[1], pre_ok[1]}, 0);
        chk("R12 legal pre", err_timing, 0);
        issue(2'b11, 2'd1, 0, 0);                // precharge of closed bank
        chk("R8 idle pre state", bank_open, 0);
        chk("R8 idle pre errs", {err_act_open, err_col_closed, err_timing}, 0);
        chk("R8 act_ok", act_ok, 4'hF);
    endtask

    task automatic t_early;
        issue(2'b00, 2'd2, 13'h005, 0);
        issue(2'b00, 2'd3, 13'h006, 0);          // rrd not met
        chk("R12 early act flagged", err_timing, 1);
        chk("R12 early act applied", bank_open, 4'b1100);
        issue(2'b10, 2'd2, 0, 10'h011);          // write at age 2
        chk("R12 early write flagged", err_timing, 1);
        chk("R12 early write applied", col_addr, 10'h011);
        issue(2'b11, 2'd2, 0, 0);                // precharge at age 3
        chk("R12 early pre flagged", err_timing, 1);
        chk("R12 early pre applied", bank_open, 4'b1000);
        idle(1);
        chk("R12 pulse ends", err_timing, 0);
        issue(2'b11, 2'd3, 0, 0);
        idle(3);
        chk("R8 all closed", bank_open, 0);
    endtask

    task automatic t_illegal;
        issue(2'b00, 2'd0, 13'h077, 0);
        issue(2'b00, 2'd0, 13'h055, 0);
        chk("R9 err_act_open", err_act_open, 1);
        chk("R9 row kept", row_of(0), 13'h077);
        idle(1);
        chk("R9 pulse ends", err_act_open, 0);
        issue(2'b01, 2'd2, 0, 10'h3FF);
        chk("R10 err_col_closed", err_col_closed, 1);
        chk("R10 col kept", col_addr, 10'h011);
        chk("R10 col bank kept", col_bank, 2'd2);
        idle(6);
        issue(2'b11, 2'd0, 0, 0);
        chk("R8 bank0 closed", bank_open, 0);
        idle(2);
    endtask

    task automatic t_aging;
        issue(2'b00, 2'd3, 13'h1AB, 0);          // age 1
        idle(40);                                 // age 41
        chk("R6 force at 41", force_pre_req, 0);
        idle(1);                                  // age 42
        chk("R6 force at 42", force_pre_req, 4'b1000);
        idle(8);                                  // age 50
        chk("R7 overdue at 50", ras_overdue, 0);
        idle(1);                                  // age 51
        chk("R7 overdue at 51", ras_overdue, 4'b1000);
        idle(5);
        chk("R7 overdue holds", ras_overdue, 4'b1000);
        chk("R6 force holds", force_pre_req, 4'b1000);
        issue(2'b11, 2'd3, 0, 0);
        chk("R8 aging cleared", {force_pre_req, ras_overdue, bank_open}, 0);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_open_and_column();
        t_early();
        t_illegal();
        t_aging();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

endmodule